// File: doc/BRIEF.md
# Multi-Mode DMA Transfer Sequencer

This block sequences byte transfers for a small multi-channel DMA controller. Each channel has a request line, a byte counter, a unit-size select and a two-bit transfer-condition select. The block gives the bus to one channel at a time. While a channel holds the bus, it issues one byte-beat strobe per clock, tagged with the channel index, and decrements that channel's counter.

The transfer-condition select sets how often the bus is re-arbitrated. In unit mode, one request moves one unit and the channel then needs a new request. In sequential mode, one request runs the channel down to zero, and other channels may take the bus at each unit boundary. In non-stop mode, one request runs the channel down to zero with no arbitration until it finishes.

Counters are loaded through a shared value bus with one load strobe per channel. A done pulse marks the beat that empties a counter. Address generation and the memory bus protocol are handled elsewhere; this block supplies only beat timing and channel selection.

Top module: `dma_seq_top`

## Requirements
- R1: After reset no beat is issued, every byte counter reads zero and no done bit is set.
- R2: At most one beat is issued per clock. `beat_ch_o` names the channel that holds the bus, and a beat is issued on every clock while a channel holds it.
- R3: Each beat decrements the byte counter of the channel named on `beat_ch_o` by exactly one.
- R4: Condition code 2'b00 (unit mode): a request pulse is remembered until the channel is granted. Each grant moves exactly one unit, and the channel then waits for a new request before moving its next unit.
- R5: Condition code 2'b10 is reserved and behaves exactly like unit mode.
- R6: Condition code 2'b01 (sequential mode): one request keeps the channel moving unit after unit until its counter is zero, with no further requests.
- R7: In sequential mode, arbitration is redone at the end of every unit. A pending higher-priority channel takes the bus there, and the preempted channel resumes later without a new request.
- R8: Condition code 2'b11 (non-stop mode): once granted, the channel keeps the bus until its counter is zero. Requests from all other channels are held off until then.
- R9: Priority is fixed, with channel 0 highest. Arbitration happens only while the bus is idle or at a boundary that the holder's mode permits.
- R10: The unit-size select of each channel (3 bits) encodes 0:1, 1:2, 2:4, 3:8, 4:16 bytes, and 5 to 7 also give 16 bytes. When fewer bytes remain than one unit, the final unit is cut short at zero.
- R11: `done_o[c]` is a one-cycle pulse on the clock of the beat that takes channel c's counter to zero, and only then.
- R12: A channel whose counter is zero ignores requests and issues no beats.
- R13: A load strobe writes `cnt_ld_val_i` into a channel's counter only while that counter is zero; otherwise the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_CH | Per-channel transfer request |
| cnt_ld_i | input | NUM_CH | Per-channel counter load strobe |
| cnt_ld_val_i | input | CNT_W | Shared counter load value |
| mode_i | input | 2*NUM_CH | Transfer-condition code, 2 bits per channel |
| size_i | input | 3*NUM_CH | Unit-size select, 3 bits per channel |
| beat_o | output | 1 | Byte-beat strobe |
| beat_ch_o | output | log2(NUM_CH) | Channel that owns the current beat |
| done_o | output | NUM_CH | Per-channel transfer-complete pulse |
| cnt_o | output | CNT_W*NUM_CH | Per-channel remaining byte count |

## Verification
The bench builds the block with NUM_CH=4 and CNT_W=10. Four channels give room to run unit, reserved, sequential and non-stop channels side by side and contending at the same boundaries, so preemption, hold-off and the full priority order all appear. A 10-bit counter keeps random loads short, so transfers run to zero often, and short final units, done pulses and ignored requests on empty channels occur many times in a few thousand cycles.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int SEL_W = 3;
  localparam int UL_W  = 5;

  typedef enum logic [1:0] {
    MODE_UNIT    = 2'b00,
    MODE_SEQ     = 2'b01,
    MODE_RSVD    = 2'b10,
    MODE_NONSTOP = 2'b11
  } mode_e;

  function automatic logic [UL_W-1:0] unit_bytes(input logic [SEL_W-1:0] sel);
    unique case (sel)
      3'd0:    unit_bytes = UL_W'(1);
      3'd1:    unit_bytes = UL_W'(2);
      3'd2:    unit_bytes = UL_W'(4);
      3'd3:    unit_bytes = UL_W'(8);
      default: unit_bytes = UL_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_chan.sv
module dma_seq_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             dec_i,
  input  logic             grant_i,
  input  logic             set_seq_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             elig_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             req_lat_q;
  logic             seq_pend_q;
  logic             empty;
  logic             finishing;

  assign empty     = (cnt_q == '0);
  assign last_o    = (cnt_q == CNT_W'(1));
  assign finishing = dec_i && last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_i && empty) begin
      cnt_q <= ld_val_i;
    end else if (dec_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // request memory: cleared at completion, new request beats grant clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_lat_q <= 1'b0;
    end else if (finishing) begin
      req_lat_q <= 1'b0;
    end else if (req_i && !empty) begin
      req_lat_q <= 1'b1;
    end else if (grant_i) begin
      req_lat_q <= 1'b0;
    end
  end

  // sequential continuation survives preemption until count hits zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_pend_q <= 1'b0;
    end else if (finishing) begin
      seq_pend_q <= 1'b0;
    end else if (set_seq_i) begin
      seq_pend_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign elig_o = (req_lat_q || seq_pend_q) && !empty && !finishing;

endmodule

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic [CH_W-1:0]   idx_o,
  output logic              vld_o
);

  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = CH_W'(i);
        vld_o = 1'b1;
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    if (vld_o) gnt_o[idx_o] = 1'b1;
  end

endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       req_i,
  input  logic [NUM_CH-1:0]       cnt_ld_i,
  input  logic [CNT_W-1:0]        cnt_ld_val_i,
  input  logic [2*NUM_CH-1:0]     mode_i,
  input  logic [SEL_W*NUM_CH-1:0] size_i,
  output logic                    beat_o,
  output logic [CH_W-1:0]         beat_ch_o,
  output logic [NUM_CH-1:0]       done_o,
  output logic [CNT_W*NUM_CH-1:0] cnt_o
);

  logic            busy_q;
  logic [CH_W-1:0] cur_q;
  logic [UL_W-1:0] ul_q;

  logic [NUM_CH-1:0] dec;
  logic [NUM_CH-1:0] last;
  logic [NUM_CH-1:0] elig;
  logic [NUM_CH-1:0] gnt_sel;
  logic [NUM_CH-1:0] grant;
  logic [NUM_CH-1:0] set_seq;
  logic [CH_W-1:0]   win_idx;
  logic              win_vld;

  mode_e cur_mode;
  logic  cur_last;
  logic  unit_end;
  logic  arb_en;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign dec[g]     = busy_q && (cur_q == CH_W'(g));
    assign set_seq[g] = grant[g] && (mode_e'(mode_i[2*g +: 2]) == MODE_SEQ);

    dma_seq_chan #(
      .CNT_W(CNT_W)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_i[g]),
      .ld_i     (cnt_ld_i[g]),
      .ld_val_i (cnt_ld_val_i),
      .dec_i    (dec[g]),
      .grant_i  (grant[g]),
      .set_seq_i(set_seq[g]),
      .cnt_o    (cnt_o[g*CNT_W +: CNT_W]),
      .last_o   (last[g]),
      .elig_o   (elig[g])
    );
  end

  dma_seq_arb #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W)
  ) u_arb (
    .req_i(elig),
    .gnt_o(gnt_sel),
    .idx_o(win_idx),
    .vld_o(win_vld)
  );

  assign cur_mode = mode_e'(mode_i[cur_q*2 +: 2]);
  assign cur_last = last[cur_q];
  assign unit_end = busy_q && ((ul_q == UL_W'(1)) || cur_last);
  // non-stop holder blocks arbitration until its final beat
  assign arb_en   = !busy_q || (unit_end && (cur_last || (cur_mode != MODE_NONSTOP)));
  assign grant    = arb_en ? gnt_sel : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      ul_q   <= '0;
    end else if (arb_en) begin
      busy_q <= win_vld;
      if (win_vld) begin
        cur_q <= win_idx;
        ul_q  <= unit_bytes(size_i[win_idx*SEL_W +: SEL_W]);
      end
    end else if (busy_q) begin
      if (unit_end) ul_q <= unit_bytes(size_i[cur_q*SEL_W +: SEL_W]);
      else          ul_q <= ul_q - UL_W'(1);
    end
  end

  assign beat_o    = busy_q;
  assign beat_ch_o = cur_q;
  assign done_o    = dec & last;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int CH_W   = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [2*NUM_CH-1:0]     mode_i,
  input logic                    beat_o,
  input logic [CH_W-1:0]         beat_ch_o,
  input logic [NUM_CH-1:0]       done_o,
  input logic [CNT_W*NUM_CH-1:0] cnt_o
);

  logic [CNT_W-1:0] beat_cnt;
  assign beat_cnt = cnt_o[beat_ch_o*CNT_W +: CNT_W];

  // R11
  a_r11_done_on_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |-> (beat_o && (done_o == (NUM_CH'(1) << beat_ch_o))));

  // R11
  a_r11_done_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |=> (cnt_o[$past(beat_ch_o)*CNT_W +: CNT_W] == '0));

  // R3
  a_r3_count_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |=> (cnt_o[$past(beat_ch_o)*CNT_W +: CNT_W] == $past(beat_cnt) - CNT_W'(1)));

  // R12
  a_r12_no_empty_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |-> (beat_cnt != '0));

  // R8
  a_r8_nonstop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && (mode_i[beat_ch_o*2 +: 2] == 2'b11) && (beat_cnt != CNT_W'(1)))
    |=> (beat_o && (beat_ch_o == $past(beat_ch_o))));

endmodule

bind dma_seq_top dma_seq_chk #(
  .NUM_CH(NUM_CH),
  .CNT_W (CNT_W),
  .CH_W  (CH_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .beat_o   (beat_o),
  .beat_ch_o(beat_ch_o),
  .done_o   (done_o),
  .cnt_o    (cnt_o)
);

// File: tb/dma_seq_top_tb_top.sv
module dma_seq_top_tb_top;

  localparam int NUM = 4;
  localparam int CW  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM-1:0]    req = '0;
  logic [NUM-1:0]    ld = '0;
  logic [CW-1:0]     ld_val = '0;
  logic [2*NUM-1:0]  mode = '0;
  logic [3*NUM-1:0]  size = '0;
  logic              beat;
  logic [1:0]        beat_ch;
  logic [NUM-1:0]    done;
  logic [CW*NUM-1:0] cnt;

  always #10 clk = ~clk;

  dma_seq_top #(.NUM_CH(NUM), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cnt_ld_i(ld),
    .cnt_ld_val_i(ld_val), .mode_i(mode), .size_i(size),
    .beat_o(beat), .beat_ch_o(beat_ch), .done_o(done), .cnt_o(cnt)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  int m_cnt[NUM];
  bit m_lat[NUM];
  bit m_pend[NUM];
  bit m_busy;
  int m_cur;
  int m_ul;

  int log_ch[1024];
  int n_log;
  int done_cnt[NUM];

  task automatic check(bit ok, string rq, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int ub(int s);
    return (s >= 4) ? 16 : (1 << s);
  endfunction

  function automatic int cnt_of(int c);
    return int'(cnt[c*CW +: CW]);
  endfunction

  task automatic model_step();
    bit last, uend, arb;
    int win;
    int n_cnt[NUM];
    bit n_lat[NUM];
    bit n_pend[NUM];
    last = m_busy && (m_cnt[m_cur] == 1);
    uend = m_busy && ((m_ul == 1) || last);
    arb  = !m_busy || (uend && (last || (mode[m_cur*2 +: 2] != 2'b11)));
    win  = -1;
    for (int c = NUM - 1; c >= 0; c--)
      if ((m_lat[c] || m_pend[c]) && m_cnt[c] != 0 && !(m_busy && c == m_cur && last)) win = c;
    for (int c = 0; c < NUM; c++) begin
      bool_fin: begin end
      n_cnt[c]  = m_cnt[c];
      n_lat[c]  = m_lat[c];
      n_pend[c] = m_pend[c];
      if (ld[c] && m_cnt[c] == 0) n_cnt[c] = int'(ld_val);
      else if (m_busy && c == m_cur) n_cnt[c] = m_cnt[c] - 1;
      if (m_busy && c == m_cur && last) n_lat[c] = 0;
      else if (req[c] && m_cnt[c] != 0) n_lat[c] = 1;
      else if (arb && win == c) n_lat[c] = 0;
      if (m_busy && c == m_cur && last) n_pend[c] = 0;
      else if (arb && win == c && mode[c*2 +: 2] == 2'b01) n_pend[c] = 1;
    end
    if (arb) begin
      m_busy = (win >= 0);
      if (win >= 0) begin
        m_cur = win;
        m_ul  = ub(int'(size[win*3 +: 3]));
      end
    end else if (m_busy) begin
      if (uend) m_ul = ub(int'(size[m_cur*3 +: 3]));
      else      m_ul = m_ul - 1;
    end
    for (int c = 0; c < NUM; c++) begin
      m_cnt[c]  = n_cnt[c];
      m_lat[c]  = n_lat[c];
      m_pend[c] = n_pend[c];
    end
  endtask

  task automatic tick();
    logic [NUM-1:0] dexp;
    model_step();
    @(negedge clk);
    check(beat == m_busy, "R2 beat", int'(beat), int'(m_busy));
    if (m_busy) check(int'(beat_ch) == m_cur, "R2 channel", int'(beat_ch), m_cur);
    for (int c = 0; c < NUM; c++)
      check(cnt_of(c) == m_cnt[c], "R3 count", cnt_of(c), m_cnt[c]);
    dexp = '0;
    if (m_busy && m_cnt[m_cur] == 1) dexp[m_cur] = 1'b1;
    check(done == dexp, "R11 done", int'(done), int'(dexp));
    if (beat && n_log < 1024) begin
      log_ch[n_log] = int'(beat_ch);
      n_log++;
    end
    for (int c = 0; c < NUM; c++) if (done[c]) done_cnt[c]++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic cfg(int c, int md, int sz);
    mode[c*2 +: 2] = 2'(md);
    size[c*3 +: 3] = 3'(sz);
  endtask

  task automatic load(int c, int v);
    ld[c] = 1'b1;
    ld_val = CW'(v);
    tick();
    ld[c] = 1'b0;
  endtask

  task automatic pulse(logic [NUM-1:0] m);
    req = m;
    tick();
    req = '0;
  endtask

  task automatic clr_log();
    n_log = 0;
    for (int c = 0; c < NUM; c++) done_cnt[c] = 0;
  endtask

  function automatic int nbeats(int c);
    int n = 0;
    for (int i = 0; i < n_log; i++) if (log_ch[i] == c) n++;
    return n;
  endfunction

  function automatic int first_of(int c);
    for (int i = 0; i < n_log; i++) if (log_ch[i] == c) return i;
    return -1;
  endfunction

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NUM; c++) begin
      m_cnt[c] = 0; m_lat[c] = 0; m_pend[c] = 0;
    end
    m_busy = 0; m_cur = 0; m_ul = 0;
    clr_log();
    void'($urandom(32'd4711));

    // R1 reset state
    @(negedge clk);
    @(negedge clk);
    check(beat == 1'b0, "R1 beat", int'(beat), 0);
    check(cnt == '0, "R1 count", int'(cnt[CW-1:0]), 0);
    check(done == '0, "R1 done", int'(done), 0);
    rst_n = 1'b1;

    // R4 unit mode: 4-byte units from 10 bytes
    cfg(0, 0, 2);
    load(0, 10);
    clr_log();
    pulse(4'b0001); run(20);
    check(nbeats(0) == 4, "R4 first unit", nbeats(0), 4);
    check(cnt_of(0) == 6, "R4 waits", cnt_of(0), 6);
    pulse(4'b0001); run(20);
    check(nbeats(0) == 8, "R4 second unit", nbeats(0), 8);
    pulse(4'b0001); run(20);
    check(nbeats(0) == 10, "R10 short final unit", nbeats(0), 10);
    check(done_cnt[0] == 1, "R11 one done", done_cnt[0], 1);

    // R5 reserved code acts as unit mode
    cfg(1, 2, 1);
    load(1, 5);
    clr_log();
    pulse(4'b0010); run(20);
    check(nbeats(1) == 2, "R5 reserved unit", nbeats(1), 2);
    check(cnt_of(1) == 3, "R5 waits", cnt_of(1), 3);
    pulse(4'b0010); run(10);
    pulse(4'b0010); run(10);
    check(cnt_of(1) == 0, "R5 drained", cnt_of(1), 0);

    // R6 sequential runs out on one request
    cfg(1, 1, 1);
    load(1, 7);
    clr_log();
    pulse(4'b0010); run(20);
    check(nbeats(1) == 7, "R6 sequential", nbeats(1), 7);
    check(done_cnt[1] == 1, "R11 seq done", done_cnt[1], 1);

    // R10 size encodings 8 and clamped 16
    cfg(0, 0, 3);
    load(0, 3);
    clr_log();
    pulse(4'b0001); run(15);
    check(nbeats(0) == 3, "R10 shortened unit", nbeats(0), 3);
    cfg(0, 0, 7);
    load(0, 20);
    clr_log();
    pulse(4'b0001); run(30);
    check(nbeats(0) == 16, "R10 code 7 is 16", nbeats(0), 16);
    pulse(4'b0001); run(10);

    // R7 sequential preempted at unit boundary, then resumes
    cfg(2, 1, 2);
    cfg(0, 0, 1);
    load(2, 12);
    load(0, 2);
    clr_log();
    pulse(4'b0100); run(2);
    pulse(4'b0001); run(30);
    check(first_of(0) == 4, "R7 preempt at boundary", first_of(0), 4);
    check(nbeats(0) == 2, "R7 preemptor unit", nbeats(0), 2);
    check(nbeats(2) == 12, "R7 resumed", nbeats(2), 12);

    // R8 non-stop holds off channel 0
    cfg(3, 3, 0);
    cfg(0, 0, 0);
    load(3, 9);
    load(0, 1);
    clr_log();
    pulse(4'b1000); run(2);
    pulse(4'b0001); run(30);
    check(first_of(0) == 9, "R8 held off", first_of(0), 9);
    check(nbeats(3) == 9, "R8 non-stop total", nbeats(3), 9);

    // R9 fixed priority
    for (int c = 0; c < NUM; c++) begin
      cfg(c, 0, 0);
      load(c, 2);
    end
    clr_log();
    pulse(4'b1111); run(20);
    for (int c = 0; c < NUM; c++)
      check(log_ch[c] == c, "R9 priority order", log_ch[c], c);
    pulse(4'b1111); run(20);

    // R12 empty channel ignores requests
    clr_log();
    pulse(4'b0010); run(10);
    check(n_log == 0, "R12 no beats", n_log, 0);
    check(cnt_of(1) == 0, "R12 count stays", cnt_of(1), 0);

    // R13 load only when empty
    load(1, 5);
    check(cnt_of(1) == 5, "R13 load empty", cnt_of(1), 5);
    load(1, 9);
    check(cnt_of(1) == 5, "R13 load ignored", cnt_of(1), 5);
    cfg(1, 1, 4);
    pulse(4'b0010); run(10);
    check(cnt_of(1) == 0, "R13 drained", cnt_of(1), 0);

    // random mix checked cycle by cycle against the model
    for (int i = 0; i < 5000; i++) begin
      for (int c = 0; c < NUM; c++) begin
        req[c] = (($urandom % 6) == 0);
        ld[c]  = (($urandom % 10) == 0);
        if (($urandom % 80) == 0) cfg(c, int'($urandom % 4), int'($urandom % 8));
      end
      ld_val = CW'($urandom % 48);
      tick();
    end
    req = '0;
    ld  = '0;
    run(20);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule